// File: doc/BRIEF.md
# Power Supply Supervisor Sequencer

This block is the digital timing and protection core of a supervisor for a multi-rail power supply. It receives comparator flags that are already digital: over-voltage, under-voltage and over-current for each rail, one power-good-input flag, and an active-low on/off request. Each input passes through a glitch filter that requires the input to be stable for a set time. The over-current filter is longer than the others, and the on/off request has a long debounce.

A fault latch shuts the supply down through `fault_o`. Only an off command, followed by an extra delay, releases it. Under-voltage and over-current faults are masked for a start-up window after the supply is enabled. The window is short if the power-good input is already valid at that moment and long if it is not. Over-voltage is never masked. `pg_o` rises a fixed delay after the filtered power-good input becomes valid. All timers count ticks of a prescaler, so the times scale with the parameters.

Top module: `psu_supervisor`

## Requirements
- R1: Immediately after reset `fault_o` is 1 and `pg_o` is 0.
- R2: The on/off request (`off_req_i`, 1 = off, 0 = on) takes effect only after it has been stable for DEBOUNCE ticks. A shorter low pulse leaves `fault_o` at 1.
- R3: Over-voltage, under-voltage and power-good-input flags are accepted only after GLITCH_FAST stable ticks. A shorter over-voltage pulse leaves `fault_o` at 0.
- R4: Over-current flags are accepted only after GLITCH_SLOW stable ticks. A pulse that would pass the fast filter but is shorter than GLITCH_SLOW has no effect, and a long one sets the fault.
- R5: `pg_o` rises PG_DELAY ticks after the filtered power-good input becomes valid. It falls as soon as the filtered power-good input becomes invalid.
- R6: An accepted fault sets a latch that holds `fault_o` at 1 and `pg_o` at 0 after the fault flag is removed.
- R7: The latch is released only by a debounced off command. `fault_o` follows that off command after a further OFF_EXTRA ticks. A later on command then brings `fault_o` to 0.
- R8: When `fault_o` falls while the filtered power-good input is valid, under-voltage and over-current faults are ignored for MASK_PG ticks.
- R9: When `fault_o` falls while the filtered power-good input is invalid, the mask lasts MASK_NOPG ticks.
- R10: An accepted over-voltage fault sets the latch even inside the start-up mask.
- R11: A debounced off command forces `pg_o` to 0 at once, before `fault_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ov_i | input | N_RAILS | Over-voltage flag for each rail |
| uv_i | input | N_RAILS | Under-voltage flag for each rail |
| oc_i | input | N_RAILS | Over-current flag for each rail |
| pg_in_i | input | 1 | Power-good input flag, 1 = valid |
| off_req_i | input | 1 | On/off request, 1 = off, 0 = on |
| fault_o | output | 1 | 1 = supply must be shut down |
| pg_o | output | 1 | 1 = rails valid |

## Verification
The hardest situations to reach from the ports are the two start-up mask lengths. Each one needs an under-voltage flag that has already been accepted before the supply is enabled, with the power-good input set to the wanted level beforehand. The bench holds the flag through the enable and then samples `fault_o` on both sides of the short and the long window boundary. Over-voltage is raised inside the window to show that the mask does not cover it. The release delay is checked by sampling between the debounce end and the extra delay, where `pg_o` must already be 0 and `fault_o` must still be 0.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;
  localparam int unsigned RAILS_DEF = 5;

  function automatic int unsigned tmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psu_tick_gen.sv
module psu_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/psu_filt.sv
// Output takes the input value once it has differed for N consecutive ticks.
module psu_filt #(
  parameter int unsigned N       = 73,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q;
  logic          q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= RST_VAL;
      cnt_q <= '0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        q_q   <= d_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/psu_filt_bank.sv
module psu_filt_bank #(
  parameter int unsigned W = 5,
  parameter int unsigned N = 73
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_ch
    psu_filt #(.N(N), .RST_VAL(1'b0)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .d_i   (d_i[i]),
      .q_o   (q_o[i])
    );
  end
endmodule

// File: rtl/psu_hold.sv
// Rising edge delayed by N ticks, falling edge immediate.
module psu_hold #(
  parameter int unsigned N = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL = CW'(N);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!d_i) cnt_q <= '0;
    else if (tick_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign q_o = d_i && (cnt_q == FULL);
endmodule

// File: rtl/psu_startup_mask.sv
// Mask window after enable; length picked from power-good state at enable.
module psu_startup_mask #(
  parameter int unsigned SHORT_T = 75,
  parameter int unsigned LONG_T  = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic pg_ok_i,
  output logic mask_o
);
  localparam int unsigned MX = psu_sup_pkg::tmax(SHORT_T, LONG_T);
  localparam int unsigned CW = $clog2(MX + 1);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_T);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_T);

  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic [CW-1:0] lim;

  assign lim = long_q ? LONG_L : SHORT_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      long_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q  <= '0;
      long_q <= !pg_ok_i;
    end else if (tick_i && cnt_q != lim) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mask_o = (cnt_q != lim);
endmodule

// File: rtl/psu_supervisor.sv
module psu_supervisor #(
  parameter int unsigned N_RAILS     = psu_sup_pkg::RAILS_DEF,
  parameter int unsigned TICK_DIV    = 100,
  parameter int unsigned GLITCH_FAST = 73,
  parameter int unsigned GLITCH_SLOW = 1200,
  parameter int unsigned DEBOUNCE    = 38000,
  parameter int unsigned OFF_EXTRA   = 3500,
  parameter int unsigned PG_DELAY    = 300000,
  parameter int unsigned MASK_PG     = 75000,
  parameter int unsigned MASK_NOPG   = 300000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_RAILS-1:0] ov_i,
  input  logic [N_RAILS-1:0] uv_i,
  input  logic [N_RAILS-1:0] oc_i,
  input  logic               pg_in_i,
  input  logic               off_req_i,
  output logic               fault_o,
  output logic               pg_o
);
  logic               tick;
  logic [N_RAILS-1:0] ov_f, uv_f, oc_f;
  logic               pg_f, off_db, off_st, mask, latch_q, set_fault, pg_cond;

  psu_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  psu_filt_bank #(.W(N_RAILS), .N(GLITCH_FAST)) u_ov_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .d_i(ov_i), .q_o(ov_f)
  );
  psu_filt_bank #(.W(N_RAILS), .N(GLITCH_FAST)) u_uv_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .d_i(uv_i), .q_o(uv_f)
  );
  psu_filt_bank #(.W(N_RAILS), .N(GLITCH_SLOW)) u_oc_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .d_i(oc_i), .q_o(oc_f)
  );
  psu_filt #(.N(GLITCH_FAST), .RST_VAL(1'b0)) u_pg_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .d_i(pg_in_i), .q_o(pg_f)
  );
  psu_filt #(.N(DEBOUNCE), .RST_VAL(1'b1)) u_off_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .d_i(off_req_i), .q_o(off_db)
  );

  // Off command reaches the fault output only after the extra delay.
  psu_hold #(.N(OFF_EXTRA)) u_off_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .d_i(off_db), .q_o(off_st)
  );

  psu_startup_mask #(.SHORT_T(MASK_PG), .LONG_T(MASK_NOPG)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .run_i(!fault_o), .pg_ok_i(pg_f), .mask_o(mask)
  );

  assign set_fault = (|ov_f) || (!mask && ((|uv_f) || (|oc_f)));

  // Release dominates; it only acts once the output is already held by off_st.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b1;
    else if (off_st) latch_q <= 1'b0;
    else if (set_fault) latch_q <= 1'b1;
  end

  assign fault_o = latch_q || off_st;
  assign pg_cond = pg_f && !fault_o && !off_db;

  psu_hold #(.N(PG_DELAY)) u_pg_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .d_i(pg_cond), .q_o(pg_o)
  );
endmodule

// File: rtl/psu_supervisor_chk.sv
module psu_supervisor_chk #(
  parameter int unsigned N_RAILS = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fault_o,
  input logic               pg_o,
  input logic               off_db,
  input logic               pg_f,
  input logic [N_RAILS-1:0] ov_f
);
  assert_pg_blocked_by_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_o |-> !fault_o);

  assert_pg_low_when_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_db |-> !pg_o);

  assert_release_needs_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> !off_db);

  assert_ov_never_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_f != '0) |=> fault_o);

  assert_pg_after_filter_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_o) |-> $past(pg_f));
endmodule

bind psu_supervisor psu_supervisor_chk #(.N_RAILS(N_RAILS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fault_o(fault_o),
  .pg_o   (pg_o),
  .off_db (off_db),
  .pg_f   (pg_f),
  .ov_f   (ov_f)
);

// File: tb/psu_supervisor_tb.sv
module psu_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] ov = '0, uv = '0, oc = '0;
  logic          pg_in = 1'b0;
  logic          off_req = 1'b1;
  logic          fault, pg;
  int            checks = 0;
  int            errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  psu_supervisor #(
    .N_RAILS(NR), .TICK_DIV(2), .GLITCH_FAST(4), .GLITCH_SLOW(12),
    .DEBOUNCE(20), .OFF_EXTRA(10), .PG_DELAY(40), .MASK_PG(30), .MASK_NOPG(80)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ov_i(ov), .uv_i(uv), .oc_i(oc),
    .pg_in_i(pg_in), .off_req_i(off_req), .fault_o(fault), .pg_o(pg)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_on(input string req);
    int k = 0;
    off_req = 1'b0;
    while (fault !== 1'b0 && k < 200) begin
      cyc(1);
      k++;
    end
    chk(fault, 1'b0, req);
  endtask

  task automatic power_off();
    off_req = 1'b1;
    cyc(100);
  endtask

  task automatic t_reset();
    chk(fault, 1'b1, "R1 fault");
    chk(pg, 1'b0, "R1 pg");
  endtask

  task automatic t_debounce();
    off_req = 1'b0;
    cyc(20);
    off_req = 1'b1;
    cyc(60);
    chk(fault, 1'b1, "R2 short on pulse");
    off_req = 1'b0;
    cyc(30);
    chk(fault, 1'b1, "R2 before debounce");
    cyc(20);
    chk(fault, 1'b0, "R2 after debounce");
  endtask

  task automatic t_pg();
    pg_in = 1'b1;
    cyc(70);
    chk(pg, 1'b0, "R5 before delay");
    cyc(30);
    chk(pg, 1'b1, "R5 after delay");
    pg_in = 1'b0;
    cyc(4);
    chk(pg, 1'b1, "R5 drop filtered");
    cyc(10);
    chk(pg, 1'b0, "R5 drop");
    pg_in = 1'b1;
    cyc(110);
    chk(pg, 1'b1, "R5 restore");
  endtask

  task automatic t_off();
    off_req = 1'b1;
    cyc(30);
    chk(pg, 1'b1, "R11 before debounce");
    cyc(18);
    chk(pg, 1'b0, "R11 pg forced low");
    chk(fault, 1'b0, "R7 extra delay pending");
    cyc(32);
    chk(fault, 1'b1, "R7 fault after extra delay");
    cyc(20);
  endtask

  task automatic t_mask_short();
    pg_in = 1'b1;
    uv[1] = 1'b1;
    cyc(20);
    power_on("R8 enable");
    cyc(40);
    chk(fault, 1'b0, "R8 uv masked");
    cyc(40);
    chk(fault, 1'b1, "R8 uv after mask");
    uv = '0;
    power_off();
  endtask

  task automatic t_mask_long();
    pg_in = 1'b0;
    uv[3] = 1'b1;
    cyc(20);
    power_on("R9 enable");
    cyc(120);
    chk(fault, 1'b0, "R9 uv masked long");
    cyc(80);
    chk(fault, 1'b1, "R9 uv after long mask");
    uv = '0;
    power_off();
  endtask

  task automatic t_ov_unmasked();
    pg_in = 1'b1;
    cyc(20);
    power_on("R10 enable");
    cyc(10);
    ov[2] = 1'b1;
    cyc(20);
    chk(fault, 1'b1, "R10 ov in mask");
    ov = '0;
    power_off();
  endtask

  task automatic t_filters();
    power_on("R3 enable");
    cyc(150);
    chk(pg, 1'b1, "R5 pg up");
    ov[0] = 1'b1;
    cyc(4);
    ov[0] = 1'b0;
    cyc(20);
    chk(fault, 1'b0, "R3 short ov ignored");
    oc[4] = 1'b1;
    cyc(16);
    oc[4] = 1'b0;
    cyc(20);
    chk(fault, 1'b0, "R4 short oc ignored");
    ov[0] = 1'b1;
    cyc(14);
    ov[0] = 1'b0;
    cyc(30);
    chk(fault, 1'b1, "R6 latched");
    chk(pg, 1'b0, "R6 pg low");
    cyc(100);
    chk(fault, 1'b1, "R7 no self release");
  endtask

  task automatic t_release();
    power_off();
    power_on("R7 release");
    cyc(100);
    oc[4] = 1'b1;
    cyc(34);
    chk(fault, 1'b1, "R4 long oc accepted");
    oc = '0;
  endtask

  initial begin
    int k = 0;
    while (k < 150000) begin
      @(posedge clk);
      k++;
    end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    t_reset();
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    cyc(50);
    t_debounce();
    t_pg();
    t_off();
    t_mask_short();
    t_mask_long();
    t_ov_unmasked();
    t_filters();
    t_release();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule